// File: doc/BRIEF.md
# Paged External Data RAM

This block is a 1024-byte data RAM placed in a 64K external data address space. An access can present its address in one of two ways. A wide access carries a full 16-bit address. Only the low ten bits select a byte, so the RAM repeats every 0x400 bytes across the whole space. A narrow access carries only an 8-bit offset. A small page register, reached through the special-function-register (SFR) port, supplies the upper address bits and so chooses one of four 256-byte windows.

The processor issues at most one RAM access per cycle. It can read, write, or do both at one address in the same cycle. Read data comes back from a register one clock after the read strobe. The page register is read and written through a separate byte-wide SFR port. Its read is combinational, and its write is clocked.

Top module: `paged_xram`

## Requirements
- R1: The RAM holds 1024 bytes. A read presented at a rising edge drives its byte on `mem_rdata` after that edge. `mem_rdata` is 0x00 after reset.
- R2: When `mem_wide`=1, the byte reached is `mem_addr[9:0]`. Bits 15:10 have no effect, so 0x0005, 0x0405 and 0xFC05 reach the same byte.
- R3: When `mem_wide`=0, the byte reached is {page[1:0], `mem_addr[7:0]`}. Bits 15:8 have no effect. For example, page 1 with offset 0x34 reaches byte 0x134.
- R4: The page register answers at SFR address 0xAA. A write there stores `sfr_wdata[1:0]`, and a read there returns the stored page in bits 1:0.
- R5: Bits 7:2 of the page register always read as zero. Writing ones to them changes nothing.
- R6: The page register is 0x00 after reset.
- R7: A page write affects narrow accesses from the next cycle on. A narrow access in the same cycle as the page write still uses the old page.
- R8: SFR writes to any address other than 0xAA leave the page unchanged. SFR reads at other addresses return 0x00.
- R9: A read and a write to the same byte in one cycle store the new byte. The read returns the byte as it was before that write.
- R10: `mem_rdata` keeps its last value in every cycle without a read, including write-only cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational) |
| mem_rd | input | 1 | RAM read strobe |
| mem_wr | input | 1 | RAM write strobe |
| mem_wide | input | 1 | 1: 16-bit address mode, 0: 8-bit paged mode |
| mem_addr | input | 16 | RAM address (only bits 7:0 are used in paged mode) |
| mem_wdata | input | 8 | RAM write data |
| mem_rdata | output | 8 | Registered RAM read data |

## Verification
The page value shown on `sfr_rdata` is due in the same cycle as the SFR address. A page write appears there after one clock edge. A RAM read is due one edge after its strobe. The bench drives inputs on the falling edge and advances its model at the rising edge. It then compares on the following falling edge, so every result is taken exactly one edge after its stimulus. The model looks up each access with the page it held before that edge. Because of this, same-cycle page writes (R7) and read-with-write cycles (R9) are judged by the same timing rule as every other access.

// File: rtl/pxr_pkg.sv
package pxr_pkg;
  localparam int unsigned PX_DEPTH   = 1024;
  localparam int unsigned PX_DW      = 8;
  localparam int unsigned PX_PAGE_W  = 2;
  localparam int unsigned PX_BUS_AW  = 16;
  localparam int unsigned PX_SFR_AW  = 8;
  localparam int unsigned PX_AW      = $clog2(PX_DEPTH);
  localparam int unsigned PX_WIN_W   = PX_AW - PX_PAGE_W;
  localparam logic [PX_SFR_AW-1:0] PX_PAGE_SFR = 8'hAA;

  typedef enum logic {
    ACC_PAGED = 1'b0,
    ACC_WIDE  = 1'b1
  } acc_mode_e;

  // Physical byte index for one access
  function automatic logic [PX_AW-1:0] px_phys(
    input acc_mode_e              mode,
    input logic [PX_BUS_AW-1:0]   bus_addr,
    input logic [PX_PAGE_W-1:0]   page
  );
    if (mode == ACC_WIDE) return bus_addr[PX_AW-1:0];
    return {page, bus_addr[PX_WIN_W-1:0]};
  endfunction
endpackage

// File: rtl/pxr_page_reg.sv
module pxr_page_reg
  import pxr_pkg::*;
#(
  parameter int unsigned PAGE_W = PX_PAGE_W,
  parameter int unsigned SFR_AW = PX_SFR_AW,
  parameter int unsigned SFR_DW = PX_DW,
  parameter logic [SFR_AW-1:0] SFR_ID = PX_PAGE_SFR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [SFR_DW-1:0] sfr_wdata,
  output logic [SFR_DW-1:0] sfr_rdata,
  output logic [PAGE_W-1:0] page_q,
  output logic              page_wr_hit
);
  localparam int unsigned PAD_W = SFR_DW - PAGE_W;

  logic sel_hit;
  logic unused_hi;

  assign sel_hit     = (sfr_addr == SFR_ID);
  assign page_wr_hit = sfr_wr && sel_hit;
  assign unused_hi   = ^sfr_wdata[SFR_DW-1:PAGE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           page_q <= '0;
    else if (page_wr_hit) page_q <= sfr_wdata[PAGE_W-1:0];
  end

  always_comb begin
    sfr_rdata = '0;
    if (sel_hit) sfr_rdata = {{PAD_W{1'b0}}, page_q};
  end
endmodule

// File: rtl/pxr_addr_sel.sv
module pxr_addr_sel
  import pxr_pkg::*;
(
  input  logic                 wide,
  input  logic [PX_BUS_AW-1:0] bus_addr,
  input  logic [PX_PAGE_W-1:0] page,
  output logic [PX_AW-1:0]     phys_addr
);
  acc_mode_e mode;
  assign mode      = wide ? ACC_WIDE : ACC_PAGED;
  assign phys_addr = px_phys(mode, bus_addr, page);
endmodule

// File: rtl/pxr_store.sv
module pxr_store #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wdata;
  end

  // Read register samples the array before this edge's write lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= cells[addr];
  end
endmodule

// File: rtl/paged_xram.sv
module paged_xram
  import pxr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  sfr_addr,
  input  logic        sfr_wr,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  input  logic        mem_rd,
  input  logic        mem_wr,
  input  logic        mem_wide,
  input  logic [15:0] mem_addr,
  input  logic [7:0]  mem_wdata,
  output logic [7:0]  mem_rdata
);
  logic [PX_PAGE_W-1:0] page_q;
  logic                 page_wr_hit;
  logic [PX_AW-1:0]     phys_addr;
  logic                 ram_rd_en;
  logic                 ram_wr_en;

  assign ram_rd_en = mem_rd;
  assign ram_wr_en = mem_wr;

  pxr_page_reg #(
    .PAGE_W (PX_PAGE_W),
    .SFR_AW (PX_SFR_AW),
    .SFR_DW (PX_DW),
    .SFR_ID (PX_PAGE_SFR)
  ) u_page (
    .clk         (clk),
    .rst_n       (rst_n),
    .sfr_addr    (sfr_addr),
    .sfr_wr      (sfr_wr),
    .sfr_wdata   (sfr_wdata),
    .sfr_rdata   (sfr_rdata),
    .page_q      (page_q),
    .page_wr_hit (page_wr_hit)
  );

  pxr_addr_sel u_sel (
    .wide      (mem_wide),
    .bus_addr  (mem_addr),
    .page      (page_q),
    .phys_addr (phys_addr)
  );

  pxr_store #(
    .DEPTH (PX_DEPTH),
    .DW    (PX_DW)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (ram_rd_en),
    .wr_en (ram_wr_en),
    .addr  (phys_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );
endmodule

// File: rtl/pxr_checker.sv
module pxr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  sfr_addr,
  input logic [7:0]  sfr_wdata,
  input logic [7:0]  sfr_rdata,
  input logic        mem_rd,
  input logic        mem_wide,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_rdata,
  input logic [1:0]  page_q,
  input logic        page_wr_hit,
  input logic [9:0]  phys_addr
);
  AST_PAGE_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    page_wr_hit |=> page_q == $past(sfr_wdata[1:0])); // R4

  AST_PAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !page_wr_hit |=> $stable(page_q)); // R8

  AST_SFR_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == 8'hAA) |-> (sfr_rdata[7:2] == 6'd0 && sfr_rdata[1:0] == page_q)); // R5

  AST_PAGED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wide |-> (phys_addr[9:8] == page_q && phys_addr[7:0] == mem_addr[7:0])); // R3

  AST_WIDE_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wide |-> phys_addr == mem_addr[9:0]); // R2

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd |=> $stable(mem_rdata)); // R10
endmodule

bind paged_xram pxr_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sfr_addr    (sfr_addr),
  .sfr_wdata   (sfr_wdata),
  .sfr_rdata   (sfr_rdata),
  .mem_rd      (mem_rd),
  .mem_wide    (mem_wide),
  .mem_addr    (mem_addr),
  .mem_rdata   (mem_rdata),
  .page_q      (page_q),
  .page_wr_hit (page_wr_hit),
  .phys_addr   (phys_addr)
);

// File: tb/paged_xram_bench.sv
`timescale 1ns/1ps
module paged_xram_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  sfr_addr;
  logic        sfr_wr;
  logic [7:0]  sfr_wdata;
  logic [7:0]  sfr_rdata;
  logic        mem_rd;
  logic        mem_wr;
  logic        mem_wide;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] mdl_mem [1024];
  logic [1:0] mdl_pg;
  logic [7:0] mdl_rd;

  always #2.5 clk = ~clk;

  paged_xram u_paged_xram (
    .clk(clk), .rst_n(rst_n),
    .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Byte index as the requirements describe it, written arithmetically
  function automatic int exp_index(input logic wide, input logic [15:0] a, input logic [1:0] pg);
    if (wide) return int'(a) % 1024;
    return int'(pg) * 256 + int'(a) % 256;
  endfunction

  function automatic logic [7:0] fill_val(input int idx);
    return 8'((idx * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] exp_sfr(input logic [7:0] sa, input logic [1:0] pg);
    return (sa == 8'hAA) ? {6'd0, pg} : 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%02h expected=0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic step(input logic rd, input logic wr, input logic wide, input logic [15:0] a,
                      input logic [7:0] wd, input logic sw, input logic [7:0] sa,
                      input logic [7:0] swd);
    int idx;
    mem_rd = rd; mem_wr = wr; mem_wide = wide; mem_addr = a; mem_wdata = wd;
    sfr_wr = sw; sfr_addr = sa; sfr_wdata = swd;
    @(posedge clk);
    idx = exp_index(wide, a, mdl_pg);
    if (rd) mdl_rd = mdl_mem[idx];
    if (wr) mdl_mem[idx] = wd;
    if (sw && sa == 8'hAA) mdl_pg = swd[1:0];
    @(negedge clk);
    mem_rd = 1'b0; mem_wr = 1'b0; sfr_wr = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    sfr_addr = 8'hAA; sfr_wr = 1'b0; sfr_wdata = 8'h00;
    mem_rd = 1'b0; mem_wr = 1'b0; mem_wide = 1'b1; mem_addr = 16'h0; mem_wdata = 8'h0;
    mdl_pg = 2'd0; mdl_rd = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R6 page reset", sfr_rdata, 8'h00);
    check("R1 rdata reset", mem_rdata, 8'h00);

    for (int i = 0; i < 1024; i++)
      step(1'b0, 1'b1, 1'b1, 16'(i), fill_val(i), 1'b0, 8'h00, 8'h00);

    step(1'b1, 1'b0, 1'b1, 16'h0005, 8'h00, 1'b0, 8'hAA, 8'h00);
    check("R1 R2 base read", mem_rdata, fill_val(5));
    step(1'b1, 1'b0, 1'b1, 16'h03FF, 8'h00, 1'b0, 8'hAA, 8'h00);
    check("R1 top byte", mem_rdata, fill_val(1023));
    step(1'b1, 1'b0, 1'b1, 16'h0405, 8'h00, 1'b0, 8'hAA, 8'h00);
    check("R2 alias 0x0405", mem_rdata, fill_val(5));
    step(1'b1, 1'b0, 1'b1, 16'hFC05, 8'h00, 1'b0, 8'hAA, 8'h00);
    check("R2 alias 0xFC05", mem_rdata, fill_val(5));

    step(1'b0, 1'b0, 1'b1, 16'h0, 8'h00, 1'b1, 8'hAA, 8'hFF);
    check("R5 upper bits", sfr_rdata, 8'h03);
    step(1'b0, 1'b0, 1'b1, 16'h0, 8'h00, 1'b1, 8'hAA, 8'hFD);
    check("R4 R5 page write", sfr_rdata, 8'h01);

    step(1'b1, 1'b0, 1'b0, 16'hAB34, 8'h00, 1'b0, 8'hAA, 8'h00);
    check("R3 page1 offset 0x34", mem_rdata, fill_val(16'h134));

    step(1'b1, 1'b0, 1'b0, 16'h0010, 8'h00, 1'b1, 8'hAA, 8'h02);
    check("R7 same-cycle old page", mem_rdata, fill_val(16'h110));
    check("R7 page now 2", sfr_rdata, 8'h02);
    step(1'b1, 1'b0, 1'b0, 16'h5510, 8'h00, 1'b0, 8'hAA, 8'h00);
    check("R7 next-cycle new page", mem_rdata, fill_val(16'h210));

    step(1'b0, 1'b0, 1'b1, 16'h0, 8'h00, 1'b1, 8'hAB, 8'h03);
    check("R8 other sfr read", sfr_rdata, 8'h00);
    step(1'b0, 1'b0, 1'b1, 16'h0, 8'h00, 1'b0, 8'hAA, 8'h00);
    check("R8 page unchanged", sfr_rdata, 8'h02);

    step(1'b1, 1'b1, 1'b1, 16'h0200, 8'h5A, 1'b0, 8'hAA, 8'h00);
    check("R9 read old byte", mem_rdata, fill_val(16'h200));
    step(1'b1, 1'b0, 1'b1, 16'h0200, 8'h00, 1'b0, 8'hAA, 8'h00);
    check("R9 new byte stored", mem_rdata, 8'h5A);

    step(1'b0, 1'b0, 1'b1, 16'h0001, 8'h00, 1'b0, 8'hAA, 8'h00);
    check("R10 idle hold", mem_rdata, 8'h5A);
    step(1'b0, 1'b1, 1'b0, 16'h0007, 8'hC3, 1'b0, 8'hAA, 8'h00);
    check("R10 write-only hold", mem_rdata, 8'h5A);

    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      logic rd, wr, wide, sw;
      logic [15:0] a;
      logic [7:0] wd, sa, swd;
      rd = 1'($urandom % 2); wr = 1'($urandom % 3 == 0); wide = 1'($urandom % 2);
      a = 16'($urandom); wd = 8'($urandom);
      sw = 1'($urandom % 4 == 0);
      sa = ($urandom % 4 == 0) ? 8'($urandom) : 8'hAA;
      swd = 8'($urandom);
      step(rd, wr, wide, a, wd, sw, sa, swd);
      check("R1 R3 R9 R10 random rdata", mem_rdata, mdl_rd);
      check("R4 R5 R8 random sfr", sfr_rdata, exp_sfr(sa, mdl_pg));
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule